// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block makes the serial clock for a flash-oriented SPI master from the reference clock. It also gives the shift engine a launch strobe and a capture strobe, and drives an active-low slave-select field. A 16-bit control word supplies the settings: a 3-bit power-of-two divisor code, the clock polarity and phase, a master-mode bit, a manual-select bit and a 4-bit select field. A separate enable input gates the whole block.

The shift engine asks for one word of `WORD_BITS` bits with a single-cycle `start` pulse. The block answers with `busy` and with `2*WORD_BITS` serial clock edges. It ends the word with a one-cycle `done` pulse. The launch and capture strobes are registered and rise in the same cycle as the serial clock edge they belong to, so the shifter can act on them without knowing the polarity or phase. The block reads the divisor and phase when it accepts the word. A change to these settings during a word takes effect on the next word.

In manual-select mode the select field goes to the pins as written. In automatic mode the field reaches the pins only while a word is in progress.

Top module: `spi_sclk_gen`

## Requirements
- R1: The divisor code n in `cfg_word[5:3]` sets the serial clock period to (2 << n) reference cycles. Each half period is (1 << n) cycles, so code 0 divides by 2. The first edge comes (1 << n) cycles after the cycle that accepts `start`, and `busy` stays high for 2*WORD_BITS*(1 << n) cycles.
- R2: When no word is in progress, `sclk` sits at the polarity bit `cfg_word[1]`, sampled one cycle earlier.
- R3: With the phase bit `cfg_word[2]` at 0:
  - `launch` pulses in the first `busy` cycle, before any edge, and again on every trailing edge except the last.
  - `capture` pulses on every leading edge. At that moment `sclk` is the inverse of the polarity.
- R4: With the phase bit at 1, `launch` pulses on every leading edge and `capture` pulses on every trailing edge. At a capture, `sclk` equals the polarity.
- R5: A word has exactly 2*WORD_BITS toggles of `sclk`, WORD_BITS launch pulses and WORD_BITS capture pulses. Launch and capture never pulse in the same cycle.
- R6: A `start` pulse is accepted only when the block is idle, `ctrl_en` is 1 and the master bit `cfg_word[0]` is 1. `busy` rises in the next cycle. A `start` during a word has no effect.
- R7: `done` is a one-cycle pulse in the cycle of the last edge, and `busy` is low in that cycle.
- R8: The block takes the divisor code and the phase when it accepts `start`. Changing them during a word does not change that word's timing or strobes.
- R9: With the manual bit `cfg_word[14]` at 1, `ss_n` equals the select field `cfg_word[13:10]` one cycle later, whether or not a word is in progress.
- R10: With the manual bit at 0, `ss_n` equals the select field in every `busy` cycle. It is all ones otherwise, including the `done` cycle.
- R11: If `ctrl_en` is 0 or the master bit is 0, `ss_n` is all ones, `sclk` is idle and `start` is ignored. Dropping either one during a word ends the word at once, without `done`.
- R12: After reset, `busy`, `done`, `launch` and `capture` are 0, `ss_n` is all ones and `sclk` equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Global enable of the block |
| cfg_word | input | 16 | Control word: bit 0 master, bit 1 polarity, bit 2 phase, bits 5:3 divisor code, bits 13:10 select field, bit 14 manual select |
| start | input | 1 | One-cycle request for one word |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Strobe telling the shifter to drive the next bit |
| capture | output | 1 | Strobe telling the shifter to sample the input bit |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle pulse at the end of a word |
| ss_n | output | SEL_W (4) | Active-low slave-select pins |

## Verification
The hardest case to reach is a settings change in the middle of a word. The divisor, polarity and phase must change while the serial clock is running, and a second `start` must arrive at the same time. The bench starts a word at divisor code 1. Five cycles in, it rewrites the control word to the fastest divisor with the opposite polarity and phase and pulses `start` again. It then checks that every half period, the strobe levels and the total `busy` length still match the original settings. A second case that the ports do not reach easily is stopping a word partway through. The bench drops `ctrl_en` mid-word and checks that the clock returns to idle with no `done` pulse.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int CFG_W       = 16;
  localparam int MASTER_BIT  = 0;
  localparam int POL_BIT     = 1;
  localparam int PHA_BIT     = 2;
  localparam int DIV_LSB     = 3;
  localparam int SEL_LSB     = 10;
  localparam int MANUAL_BIT  = 14;
  localparam int DEF_DIV_W   = 3;
  localparam int DEF_SEL_W   = 4;
  localparam int DEF_WORD    = 8;
endpackage

// File: rtl/spi_sclk_cfg_decode.sv
module spi_sclk_cfg_decode
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = DEF_DIV_W,
  parameter int SEL_W = DEF_SEL_W
) (
  input  logic             ctrl_en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             run_ok,
  output logic             pol,
  output logic             pha,
  output logic [DIV_W-1:0] div_code,
  output logic [SEL_W-1:0] sel_field,
  output logic             manual_sel
);
  always_comb begin
    run_ok     = ctrl_en & cfg_word[MASTER_BIT];
    pol        = cfg_word[POL_BIT];
    pha        = cfg_word[PHA_BIT];
    div_code   = cfg_word[DIV_LSB +: DIV_W];
    sel_field  = cfg_word[SEL_LSB +: SEL_W];
    manual_sel = cfg_word[MANUAL_BIT];
  end
endmodule

// File: rtl/spi_sclk_edge_timer.sv
module spi_sclk_edge_timer #(
  parameter int DIV_W     = 3,
  parameter int WORD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                abort,
  input  logic [DIV_W-1:0]    div_code,
  output logic                busy,
  output logic                edge_fire,
  output logic                edge_odd,
  output logic                last_edge
);
  localparam int CNT_W  = (1 << DIV_W) - 1;
  localparam int EDGES  = 2 * WORD_BITS;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

  logic [DIV_W-1:0]  div_hold;
  logic [CNT_W-1:0]  half_cnt;
  logic [EDGE_W-1:0] edge_idx;

  function automatic logic [CNT_W-1:0] half_reload(input logic [DIV_W-1:0] d);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << d;
    return CNT_W'(span - 1'b1);
  endfunction

  always_comb begin
    edge_fire = busy && (half_cnt == '0);
    edge_odd  = edge_idx[0];
    last_edge = edge_fire && (edge_idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      div_hold <= '0;
      half_cnt <= '0;
      edge_idx <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      div_hold <= div_code;
      half_cnt <= half_reload(div_code);
      edge_idx <= '0;
    end else if (busy) begin
      if (abort) begin
        busy <= 1'b0;
      end else if (edge_fire) begin
        if (last_edge) begin
          busy <= 1'b0;
        end else begin
          edge_idx <= edge_idx + 1'b1;
          half_cnt <= half_reload(div_hold);
        end
      end else begin
        half_cnt <= half_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_phase_gen.sv
module spi_sclk_phase_gen (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic abort,
  input  logic busy,
  input  logic idle_pol,
  input  logic pha_in,
  input  logic edge_fire,
  input  logic edge_odd,
  input  logic last_edge,
  output logic sclk,
  output logic launch,
  output logic capture,
  output logic done
);
  logic pha_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk     <= idle_pol;
      launch   <= 1'b0;
      capture  <= 1'b0;
      done     <= 1'b0;
      pha_hold <= 1'b0;
    end else begin
      launch  <= 1'b0;
      capture <= 1'b0;
      done    <= 1'b0;
      if (go) begin
        pha_hold <= pha_in;
        sclk     <= idle_pol;
        launch   <= ~pha_in;
      end else if (busy && !abort) begin
        if (edge_fire) begin
          sclk    <= ~sclk;
          capture <= (edge_odd == pha_hold);
          launch  <= (edge_odd != pha_hold) && !last_edge;
          done    <= last_edge;
        end
      end else begin
        sclk <= idle_pol;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_select_drv.sv
module spi_sclk_select_drv #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_ok,
  input  logic             manual_sel,
  input  logic             hold,
  input  logic [SEL_W-1:0] sel_field,
  output logic [SEL_W-1:0] ss_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_n <= '1;
    end else if (!run_ok) begin
      ss_n <= '1;
    end else if (manual_sel || hold) begin
      ss_n <= sel_field;
    end else begin
      ss_n <= '1;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W     = DEF_DIV_W,
  parameter int SEL_W     = DEF_SEL_W,
  parameter int WORD_BITS = DEF_WORD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             start,
  output logic             sclk,
  output logic             launch,
  output logic             capture,
  output logic             busy,
  output logic             done,
  output logic [SEL_W-1:0] ss_n
);
  logic             run_ok;
  logic             pol;
  logic             pha;
  logic [DIV_W-1:0] div_code;
  logic [SEL_W-1:0] sel_field;
  logic             manual_sel;
  logic             go;
  logic             abort;
  logic             edge_fire;
  logic             edge_odd;
  logic             last_edge;
  logic             sel_hold;

  spi_sclk_cfg_decode #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_decode (
    .ctrl_en    (ctrl_en),
    .cfg_word   (cfg_word),
    .run_ok     (run_ok),
    .pol        (pol),
    .pha        (pha),
    .div_code   (div_code),
    .sel_field  (sel_field),
    .manual_sel (manual_sel)
  );

  always_comb begin
    go       = start && run_ok && !busy;
    abort    = busy && !run_ok;
    sel_hold = go || (busy && !abort && !last_edge);
  end

  spi_sclk_edge_timer #(.DIV_W(DIV_W), .WORD_BITS(WORD_BITS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .abort     (abort),
    .div_code  (div_code),
    .busy      (busy),
    .edge_fire (edge_fire),
    .edge_odd  (edge_odd),
    .last_edge (last_edge)
  );

  spi_sclk_phase_gen u_phase (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .abort     (abort),
    .busy      (busy),
    .idle_pol  (pol),
    .pha_in    (pha),
    .edge_fire (edge_fire),
    .edge_odd  (edge_odd),
    .last_edge (last_edge),
    .sclk      (sclk),
    .launch    (launch),
    .capture   (capture),
    .done      (done)
  );

  spi_sclk_select_drv #(.SEL_W(SEL_W)) u_select (
    .clk        (clk),
    .rst        (rst),
    .run_ok     (run_ok),
    .manual_sel (manual_sel),
    .hold       (sel_hold),
    .sel_field  (sel_field),
    .ss_n       (ss_n)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_en,
  input logic [15:0]      cfg_word,
  input logic             start,
  input logic             sclk,
  input logic             launch,
  input logic             capture,
  input logic             busy,
  input logic             done,
  input logic [SEL_W-1:0] ss_n
);
  // R5: the two strobes are never raised together
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(launch && capture));

  // R7: done lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy is already low when done pulses
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: an idle clock follows the polarity bit of the previous cycle
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == $past(cfg_word[1])));

  // R11: a disabled block keeps every select line high and does not run
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_en) |-> ((ss_n == '1) && !busy));

  // R6: a word begins only after a start request
  assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3, R4: capture strobes stay inside a word
  assert_capture_in_word_R4: assert property (@(posedge clk) disable iff (rst)
    capture |-> (busy || done));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_en  (ctrl_en),
  .cfg_word (cfg_word),
  .start    (start),
  .sclk     (sclk),
  .launch   (launch),
  .capture  (capture),
  .busy     (busy),
  .done     (done),
  .ss_n     (ss_n)
);

// File: tb/spi_sclk_gen_bench.sv
module spi_sclk_gen_bench;
  localparam int WORD  = 8;
  localparam int NVEC  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_en = 1'b1;
  logic [15:0] cfg_word = 16'h0000;
  logic        start = 1'b0;
  logic        sclk, launch, capture, busy, done;
  logic [3:0]  ss_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_sclk_gen u_spi_sclk_gen (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .cfg_word(cfg_word), .start(start),
    .sclk(sclk), .launch(launch), .capture(capture), .busy(busy), .done(done),
    .ss_n(ss_n)
  );

  // vector: {div[20:18], pol[17], pha[16], sel[15:12], expected busy cycles[11:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 4'b1110, 12'd16},
    {3'd1, 1'b0, 1'b1, 4'b1101, 12'd32},
    {3'd2, 1'b1, 1'b0, 4'b1011, 12'd64},
    {3'd3, 1'b1, 1'b1, 4'b0111, 12'd128},
    {3'd7, 1'b0, 1'b0, 4'b1110, 12'd2048},
    {3'd5, 1'b1, 1'b1, 4'b1101, 12'd512}
  };

  function automatic logic [15:0] mk_cfg(input logic [2:0] dv, input logic pl,
      input logic ph, input logic [3:0] sel, input logic man, input logic mst);
    logic [15:0] w;
    w = 16'h0000;
    w[0] = mst; w[1] = pl; w[2] = ph; w[5:3] = dv; w[13:10] = sel; w[14] = man;
    return w;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  int busy_cyc, toggles, launches, captures, bad_iv, bad_lvl, first_l, done_seen, bad_ss;
  logic [3:0] end_ss;
  logic       end_sclk;
  logic       pre_sclk;

  task automatic run_word(input logic [15:0] c, input logic [15:0] c_mid, input int mid_at);
    int h, s, last_t;
    logic prev, cap_lvl;
    h = 1 << c[5:3];
    cap_lvl = c[2] ? c[1] : ~c[1];
    busy_cyc = 0; toggles = 0; launches = 0; captures = 0;
    bad_iv = 0; bad_lvl = 0; first_l = -1; done_seen = 0; bad_ss = 0;
    @(negedge clk); cfg_word = c;
    @(negedge clk); pre_sclk = sclk; start = 1'b1;
    prev = sclk;
    @(negedge clk); start = 1'b0;
    s = 0; last_t = 0;
    while (s < 4000) begin
      if (busy) busy_cyc++;
      if (sclk != prev) begin
        toggles++;
        if ((s - last_t) != h) bad_iv++;
        last_t = s;
        prev = sclk;
      end
      if (launch) begin
        launches++;
        if (first_l < 0) first_l = s;
      end
      if (capture) begin
        captures++;
        if (sclk != cap_lvl) bad_lvl++;
      end
      if (busy && !c[14] && ss_n != c[13:10]) bad_ss++;
      if (done) begin
        done_seen = 1;
        break;
      end
      if (s == mid_at) begin cfg_word = c_mid; start = 1'b1; end
      if (s == mid_at + 1) start = 1'b0;
      @(negedge clk);
      s++;
    end
    start = 1'b0;
    end_ss = ss_n;
    end_sclk = sclk;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] c;
    int h;
    // reset state, R12
    cfg_word = mk_cfg(3'd0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "ss_n after reset", ss_n, 15);
    chk("R12", "sclk after reset", sclk, 1);
    chk("R12", "strobes after reset", {launch, capture, done}, 0);

    // idle polarity follows the control word, R2
    cfg_word[1] = 1'b0;
    @(negedge clk);
    chk("R2", "idle sclk after polarity change", sclk, 0);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      c = mk_cfg(VEC[i][20:18], VEC[i][17], VEC[i][16], VEC[i][15:12], 1'b0, 1'b1);
      h = 1 << VEC[i][20:18];
      run_word(c, c, -10);
      chk("R2", "idle level before word", pre_sclk, VEC[i][17]);
      chk("R1", "busy length", busy_cyc, int'(VEC[i][11:0]));
      chk("R1", "half period spacing", bad_iv, 0);
      chk("R5", "sclk toggles", toggles, 2 * WORD);
      chk("R5", "launch pulses", launches, WORD);
      chk("R5", "capture pulses", captures, WORD);
      if (VEC[i][16]) begin
        chk("R4", "sclk level at capture", bad_lvl, 0);
        chk("R4", "first launch at first edge", first_l, h);
      end else begin
        chk("R3", "sclk level at capture", bad_lvl, 0);
        chk("R3", "first launch before first edge", first_l, 0);
      end
      chk("R7", "done seen", done_seen, 1);
      chk("R10", "select during word", bad_ss, 0);
      chk("R10", "select after word", end_ss, 15);
      chk("R2", "sclk back to idle", end_sclk, VEC[i][17]);
    end

    // settings change and second start in mid word, R8 and R6
    c = mk_cfg(3'd1, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b1);
    run_word(c, mk_cfg(3'd0, 1'b1, 1'b1, 4'b1110, 1'b0, 1'b1), 5);
    chk("R8", "busy length kept", busy_cyc, 32);
    chk("R8", "half period kept", bad_iv, 0);
    chk("R8", "capture level kept", bad_lvl, 0);
    chk("R6", "restart ignored toggles", toggles, 2 * WORD);
    chk("R6", "restart ignored launches", launches, WORD);
    @(negedge clk);
    chk("R6", "no new word after restart", busy, 0);

    // manual select, R9
    cfg_word = mk_cfg(3'd0, 1'b0, 1'b0, 4'b1011, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9", "manual select idle", ss_n, 11);
    cfg_word[13:10] = 4'b0110;
    @(negedge clk);
    chk("R9", "manual select follows field", ss_n, 6);
    run_word(mk_cfg(3'd0, 1'b0, 1'b0, 4'b0110, 1'b1, 1'b1), mk_cfg(3'd0, 1'b0, 1'b0, 4'b0110, 1'b1, 1'b1), -10);
    chk("R9", "manual select after word", end_ss, 6);

    // disabled block, R11
    ctrl_en = 1'b0;
    cfg_word = mk_cfg(3'd0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R11", "disabled select high", ss_n, 15);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        if (busy || sclk) seen++;
        @(negedge clk);
      end
      chk("R11", "start ignored when disabled", seen, 0);
    end

    // master bit clear, R6
    ctrl_en = 1'b1;
    cfg_word = mk_cfg(3'd0, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R6", "start ignored without master bit", busy, 0);
    chk("R11", "select high without master bit", ss_n, 15);

    // abort in mid word, R11
    cfg_word = mk_cfg(3'd2, 1'b1, 1'b0, 4'b1110, 1'b0, 1'b1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11", "word running before abort", busy, 1);
    ctrl_en = 1'b0;
    @(negedge clk);
    chk("R11", "busy cleared by abort", busy, 0);
    chk("R11", "sclk idle after abort", sclk, 1);
    begin
      int dn = 0;
      for (int k = 0; k < 300; k++) begin
        if (done || busy) dn++;
        @(negedge clk);
      end
      chk("R11", "no done after abort", dn, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule